// File: doc/BRIEF.md
# Processor Status Word and Maskable Interrupt Acceptance

This block keeps the processor status word: eight single-bit flags (carry, debug, zero, sign, register-bank select, overflow, interrupt enable, stack-pointer select) and a 3-bit processor priority level. Each clock it weighs four possible updates in a fixed order. These are the acceptance of a pending maskable interrupt, a software interrupt, a software write of the whole word, and an update of the arithmetic flags from the ALU result. The winning update is applied to the word.

A maskable request carries a 3-bit priority. It is taken only while interrupts are enabled and only when its priority is strictly above the current level. Taking it raises a one-cycle accept pulse. It also saves the word as it stood before the change, clears interrupt enable and stack select, and loads the level with the request's priority. A software interrupt saves the word and clears stack select only for low interrupt numbers. Two direct outputs steer the datapath: one picks the stack pointer and the other picks the register bank.

Top module: `psw_status_unit`

## Requirements
- R1: After reset the flag word, the saved word and the accept output are all 0.
- R2: Bit layout of the word is carry=0, debug=1, zero=2, sign=3, bank=4, overflow=5, interrupt enable=6, stack select=7, priority level=bits 14:12. Bits 8 to 11 and 15 always read 0, and software writes to them are ignored.
- R3: A maskable request is taken only when interrupt enable (bit 6) is 1 and its priority is strictly greater than bits 14:12. An equal or lower priority, or a cleared enable, leaves the word unchanged. The accept output is high for exactly the one cycle after the edge at which the request was taken.
- R4: On acceptance, bits 6 and 7 become 0 and bits 14:12 take the request priority. The other flags are kept, and the saved output holds the word from before the edge.
- R5: A software interrupt strobe saves the current word. It clears bit 7 when the number is below 32 and leaves bit 7 unchanged for numbers 32 to 63. It changes no other bit and raises no accept.
- R6: A software write loads the word (masked per R2) when no acceptance or software interrupt occurs in the same cycle. A write beats an ALU update.
- R7: An acceptance beats a software interrupt and a software write in the same cycle. Those two are then dropped.
- R8: An ALU update changes only carry, zero, sign and overflow. Zero is 1 exactly when the result is 0, sign is the result's top bit, and carry and overflow follow their inputs.
- R9: The stack select output equals bit 7 (0 selects the interrupt stack, 1 the user stack). The bank select output equals bit 4 (0 selects bank 0, 1 selects bank 1).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| alu_upd | input | 1 | Apply ALU flags this cycle |
| alu_result | input | 16 | ALU result value |
| alu_carry | input | 1 | Carry, borrow or shifted-out bit |
| alu_ovf | input | 1 | Signed overflow from the ALU |
| sw_wr | input | 1 | Software write strobe for the whole word |
| sw_wdata | input | 16 | Word to write |
| irq_req | input | 1 | Maskable interrupt request |
| irq_pri | input | 3 | Priority of the request |
| swi_stb | input | 1 | Software interrupt strobe |
| swi_num | input | 6 | Software interrupt number |
| psw | output | 16 | Current status word |
| accept | output | 1 | One-cycle pulse on acceptance |
| psw_saved | output | 16 | Word before the last acceptance or software interrupt |
| sp_sel | output | 1 | Stack pointer select (1 = user) |
| bank_sel | output | 1 | Register bank select |

## Verification
A wrong internal state here appears on the status word one clock after the offending edge, because the word is itself the register. A bad gating decision shows on the accept pulse in that same cycle. A priority level or enable bit that is wrong stays hidden until a request arrives near the boundary. For that reason the bench drives requests at the current level, one above it, and at every level while interrupts are disabled. A behavioural model is compared against every output on every clock, so any divergence is reported on the cycle it appears.

// File: rtl/psw_pkg.sv
package psw_pkg;
  localparam int PSW_W  = 16;
  localparam int PRI_W  = 3;
  localparam int B_C    = 0;
  localparam int B_D    = 1;
  localparam int B_Z    = 2;
  localparam int B_S    = 3;
  localparam int B_B    = 4;
  localparam int B_O    = 5;
  localparam int B_I    = 6;
  localparam int B_U    = 7;
  localparam int IPL_LO = 12;
  localparam int NFLAG  = 8;

  typedef enum logic [2:0] {
    ACT_HOLD, ACT_ALU, ACT_WRITE, ACT_SWI, ACT_ACCEPT
  } psw_act_e;

  function automatic logic [PSW_W-1:0] psw_mask();
    logic [PSW_W-1:0] m;
    m = '0;
    for (int k = 0; k < NFLAG; k++) m[k] = 1'b1;
    for (int k = 0; k < PRI_W; k++) m[IPL_LO+k] = 1'b1;
    return m;
  endfunction
endpackage

// File: rtl/psw_accept_gate.sv
module psw_accept_gate
  import psw_pkg::*;
(
  input  logic             irq_req,
  input  logic [PRI_W-1:0] irq_pri,
  input  logic             ie,
  input  logic [PRI_W-1:0] ipl,
  output logic             take
);
  function automatic logic outranks(input logic [PRI_W-1:0] req, input logic [PRI_W-1:0] cur);
    return req > cur;
  endfunction

  assign take = irq_req & ie & outranks(irq_pri, ipl);
endmodule

// File: rtl/psw_alu_flags.sv
module psw_alu_flags #(
  parameter int DATA_W = 16
) (
  input  logic [DATA_W-1:0] result,
  input  logic              carry_in,
  input  logic              ovf_in,
  output logic              f_c,
  output logic              f_z,
  output logic              f_s,
  output logic              f_o
);
  function automatic logic is_zero(input logic [DATA_W-1:0] v);
    return (v == '0);
  endfunction

  function automatic logic is_neg(input logic [DATA_W-1:0] v);
    return v[DATA_W-1];
  endfunction

  assign f_c = carry_in;
  assign f_z = is_zero(result);
  assign f_s = is_neg(result);
  assign f_o = ovf_in;
endmodule

// File: rtl/psw_action_sel.sv
module psw_action_sel
  import psw_pkg::*;
(
  input  logic     take,
  input  logic     swi_stb,
  input  logic     sw_wr,
  input  logic     alu_upd,
  output psw_act_e act
);
  always_comb begin
    if (take)         act = ACT_ACCEPT;
    else if (swi_stb) act = ACT_SWI;
    else if (sw_wr)   act = ACT_WRITE;
    else if (alu_upd) act = ACT_ALU;
    else              act = ACT_HOLD;
  end
endmodule

// File: rtl/psw_state.sv
module psw_state
  import psw_pkg::*;
#(
  parameter int NUM_W       = 6,
  parameter int SWI_U_LIMIT = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  psw_act_e         act,
  input  logic             take,
  input  logic [PRI_W-1:0] irq_pri,
  input  logic [NUM_W-1:0] swi_num,
  input  logic [PSW_W-1:0] sw_wdata,
  input  logic             f_c,
  input  logic             f_z,
  input  logic             f_s,
  input  logic             f_o,
  output logic [PSW_W-1:0] word,
  output logic [PSW_W-1:0] saved,
  output logic             acc
);
  localparam logic [PSW_W-1:0] MASK = psw_mask();

  logic [PSW_W-1:0] nxt, nxt_saved;
  logic             nxt_acc;
  logic             swi_low;

  assign swi_low = (int'(swi_num) < SWI_U_LIMIT);

  always_comb begin
    nxt       = word;
    nxt_saved = saved;
    nxt_acc   = 1'b0;
    unique case (act)
      ACT_ACCEPT: begin
        nxt_saved = word;
        nxt[B_I]  = 1'b0;
        nxt[B_U]  = 1'b0;
        nxt[IPL_LO +: PRI_W] = irq_pri;
        nxt_acc   = 1'b1;
      end
      ACT_SWI: begin
        nxt_saved = word;
        if (swi_low) nxt[B_U] = 1'b0;
      end
      ACT_WRITE: nxt = sw_wdata & MASK;
      ACT_ALU: begin
        nxt[B_C] = f_c;
        nxt[B_Z] = f_z;
        nxt[B_S] = f_s;
        nxt[B_O] = f_o;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      word  <= '0;
      saved <= '0;
      acc   <= 1'b0;
    end else begin
      word  <= nxt;
      saved <= nxt_saved;
      acc   <= nxt_acc;
    end
  end

  // R3: accept pulse follows a gate decision and lasts one cycle
  assert_accept_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
    acc |=> !acc);
  assert_accept_cause_R3: assert property (@(posedge clk) disable iff (!rst_n)
    take |-> (word[B_I] && irq_pri > word[IPL_LO +: PRI_W]));
  // R4: acceptance leaves enable and stack select cleared, level loaded
  assert_accept_clears_R4: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> (!word[B_I] && !word[B_U] && word[IPL_LO +: PRI_W] == $past(irq_pri)
              && saved == $past(word)));
  // R5: high software interrupt numbers keep stack select
  assert_swi_high_keeps_u_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (act == ACT_SWI && !swi_low) |=> (word == $past(word)));
  // R8: ALU update touches only its four flags
  assert_alu_only_four_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (act == ACT_ALU) |=> (word[B_D] == $past(word[B_D]) && word[B_B] == $past(word[B_B])
                          && word[B_U:B_I] == $past(word[B_U:B_I])
                          && word[IPL_LO +: PRI_W] == $past(word[IPL_LO +: PRI_W])));
  // R2: reserved bits stay zero
  always @(posedge clk)
    if (rst_n) assert_reserved_zero_R2: assert ((word & ~MASK) == '0);
endmodule

// File: rtl/psw_status_unit.sv
module psw_status_unit
  import psw_pkg::*;
#(
  parameter int DATA_W      = 16,
  parameter int NUM_W       = 6,
  parameter int SWI_U_LIMIT = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              alu_upd,
  input  logic [DATA_W-1:0] alu_result,
  input  logic              alu_carry,
  input  logic              alu_ovf,
  input  logic              sw_wr,
  input  logic [PSW_W-1:0]  sw_wdata,
  input  logic              irq_req,
  input  logic [PRI_W-1:0]  irq_pri,
  input  logic              swi_stb,
  input  logic [NUM_W-1:0]  swi_num,
  output logic [PSW_W-1:0]  psw,
  output logic              accept,
  output logic [PSW_W-1:0]  psw_saved,
  output logic              sp_sel,
  output logic              bank_sel
);
  logic     take;
  logic     f_c, f_z, f_s, f_o;
  psw_act_e act;

  psw_accept_gate u_gate (
    .irq_req (irq_req),
    .irq_pri (irq_pri),
    .ie      (psw[B_I]),
    .ipl     (psw[IPL_LO +: PRI_W]),
    .take    (take)
  );

  psw_alu_flags #(.DATA_W(DATA_W)) u_alu (
    .result   (alu_result),
    .carry_in (alu_carry),
    .ovf_in   (alu_ovf),
    .f_c      (f_c),
    .f_z      (f_z),
    .f_s      (f_s),
    .f_o      (f_o)
  );

  psw_action_sel u_sel (
    .take    (take),
    .swi_stb (swi_stb),
    .sw_wr   (sw_wr),
    .alu_upd (alu_upd),
    .act     (act)
  );

  psw_state #(.NUM_W(NUM_W), .SWI_U_LIMIT(SWI_U_LIMIT)) u_state (
    .clk      (clk),
    .rst_n    (rst_n),
    .act      (act),
    .take     (take),
    .irq_pri  (irq_pri),
    .swi_num  (swi_num),
    .sw_wdata (sw_wdata),
    .f_c      (f_c),
    .f_z      (f_z),
    .f_s      (f_s),
    .f_o      (f_o),
    .word     (psw),
    .saved    (psw_saved),
    .acc      (accept)
  );

  assign sp_sel   = psw[B_U];
  assign bank_sel = psw[B_B];

  // R7: acceptance wins over a same-cycle write
  assert_accept_beats_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (take && sw_wr) |=> accept);
endmodule

// File: tb/psw_status_unit_tb.sv
module psw_status_unit_tb;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        alu_upd = 0, alu_carry = 0, alu_ovf = 0;
  logic [15:0] alu_result = 0;
  logic        sw_wr = 0;
  logic [15:0] sw_wdata = 0;
  logic        irq_req = 0;
  logic [2:0]  irq_pri = 0;
  logic        swi_stb = 0;
  logic [5:0]  swi_num = 0;
  logic [15:0] psw, psw_saved;
  logic        accept, sp_sel, bank_sel;

  int checks = 0, errors = 0;
  logic [15:0] m_w = 0, m_sv = 0;
  logic        m_acc = 0;

  always #2 clk = ~clk;

  psw_status_unit u_dut (
    .clk(clk), .rst_n(rst_n), .alu_upd(alu_upd), .alu_result(alu_result),
    .alu_carry(alu_carry), .alu_ovf(alu_ovf), .sw_wr(sw_wr), .sw_wdata(sw_wdata),
    .irq_req(irq_req), .irq_pri(irq_pri), .swi_stb(swi_stb), .swi_num(swi_num),
    .psw(psw), .accept(accept), .psw_saved(psw_saved), .sp_sel(sp_sel), .bank_sel(bank_sel));

  task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle();
    alu_upd = 0; sw_wr = 0; irq_req = 0; swi_stb = 0;
  endtask

  // One clock: advance the behavioural model, then compare every output.
  task automatic cyc();
    logic [15:0] w, sv;
    logic a;
    int lvl;
    w = m_w; sv = m_sv; a = 0;
    lvl = (m_w >> 12) & 7;
    if (!rst_n) begin
      w = 0; sv = 0;
    end else if (irq_req && m_w[6] && int'(irq_pri) > lvl) begin
      sv = m_w; a = 1;
      w = (m_w & 16'h8F3F) | (16'(irq_pri) << 12);
    end else if (swi_stb) begin
      sv = m_w;
      if (swi_num < 32) w = m_w & ~16'h0080;
    end else if (sw_wr) begin
      w = sw_wdata & 16'h70FF;
    end else if (alu_upd) begin
      w = m_w & ~16'h002D;
      if (alu_carry) w = w | 16'h0001;
      if (alu_result == 0) w = w | 16'h0004;
      if (alu_result >= 16'h8000) w = w | 16'h0008;
      if (alu_ovf) w = w | 16'h0020;
    end
    @(posedge clk); #1;
    m_w = w; m_sv = sv; m_acc = a;
    chk("R4 word", psw, m_w);
    chk("R3 accept", 16'(accept), 16'(m_acc));
    chk("R4 saved", psw_saved, m_sv);
    chk("R9 sp_sel", 16'(sp_sel), 16'(m_w[7]));
    chk("R9 bank_sel", 16'(bank_sel), 16'(m_w[4]));
  endtask

  task automatic wr(logic [15:0] d);
    idle(); sw_wr = 1; sw_wdata = d; cyc(); idle();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    cyc(); cyc();
    chk("R1 reset word", psw, 16'h0000);
    chk("R1 reset accept", 16'(accept), 16'h0);
    chk("R1 reset saved", psw_saved, 16'h0000);
    rst_n = 1;
    cyc();

    wr(16'hFFFF);
    chk("R2 masked write", psw, 16'h70FF);
    chk("R9 user stack", 16'(sp_sel), 16'h1);
    chk("R9 bank one", 16'(bank_sel), 16'h1);

    wr(16'h3040);
    chk("R6 write", psw, 16'h3040);
    irq_req = 1; irq_pri = 3; cyc();
    chk("R3 equal priority refused", 16'(accept), 16'h0);
    irq_pri = 4; cyc();
    chk("R3 higher accepted", 16'(accept), 16'h1);
    chk("R4 word after accept", psw, 16'h4000);
    chk("R4 saved pre word", psw_saved, 16'h3040);
    cyc();
    chk("R3 single pulse", 16'(accept), 16'h0);
    irq_pri = 7; cyc();
    chk("R3 disabled ignores", psw, 16'h4000);
    idle();

    wr(16'h00C0);
    swi_stb = 1; swi_num = 5; cyc(); idle();
    chk("R5 low number clears U", psw, 16'h0040);
    chk("R5 saved", psw_saved, 16'h00C0);
    chk("R5 no accept", 16'(accept), 16'h0);
    wr(16'h00C0);
    swi_stb = 1; swi_num = 40; cyc(); idle();
    chk("R5 high number keeps U", psw, 16'h00C0);

    irq_req = 1; irq_pri = 2; sw_wr = 1; sw_wdata = 16'hFFFF; swi_stb = 1; swi_num = 1;
    cyc(); idle();
    chk("R7 accept wins", psw, 16'h2000);
    chk("R7 accept pulse", 16'(accept), 16'h1);

    wr(16'h0000);
    alu_upd = 1; alu_result = 0; alu_carry = 1; alu_ovf = 0; cyc(); idle();
    chk("R8 zero and carry", psw, 16'h0005);
    alu_upd = 1; alu_result = 16'h8001; alu_carry = 0; alu_ovf = 1; cyc(); idle();
    chk("R8 sign and overflow", psw, 16'h0028);
    alu_upd = 1; sw_wr = 1; sw_wdata = 16'h0010; cyc(); idle();
    chk("R6 write beats ALU", psw, 16'h0010);

    for (int n = 0; n < 3000; n++) begin
      int r;
      r = $urandom % 100;
      alu_upd = (r < 40); alu_result = 16'($urandom); alu_carry = 1'($urandom); alu_ovf = 1'($urandom);
      sw_wr = (($urandom % 100) < 12); sw_wdata = 16'($urandom);
      irq_req = (($urandom % 100) < 45); irq_pri = 3'($urandom);
      swi_stb = (($urandom % 100) < 8); swi_num = 6'($urandom);
      if (($urandom % 400) == 0) rst_n = 0; else rst_n = 1;
      cyc();
    end
    idle(); rst_n = 1; cyc();

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule